// File: doc/BRIEF.md
# Transmit Start-Threshold Gate

This block is a byte-wide transmit packet buffer. It decides when the line side may begin sending a packet. The host writes bytes into the buffer, and an end-of-packet flag marks the last byte of each packet. The line side offers one byte slot per `line_slot` pulse. Once a packet has started, every slot must carry a byte, because transmission cannot pause in the middle of a packet.

A packet is allowed to start when the number of buffered bytes reaches a start level. That level is chosen by a 2-bit code together with a line-speed bit. Faster lines drain the buffer sooner, so they use a separate table with larger levels. A hold-until-complete mode replaces the level and waits until the whole packet has been buffered. If the buffer runs dry before the end-of-packet byte has gone out, the block emits an abort strobe and drops the rest of that packet. It also raises a sticky interrupt and steps its own start level up by one. When an underflow occurs at the highest level, the block switches to hold-until-complete mode and stays there until reset.

Top module: `tx_start_gate`

## Requirements
- R1: With `cfg_fast`=0, codes 0, 1, 2 and 3 give start levels of 72, 96, 128 and 160 bytes. A packet does not start with one byte fewer than its level buffered, and it starts in the next slot once the level is reached.
- R2: With `cfg_fast`=1, codes 0, 1, 2 and 3 give start levels of 128, 256, 512 and 1024 bytes. The start rule is the same as in R1.
- R3: A packet whose end-of-packet byte is already buffered starts in the next slot, even when it is shorter than the start level.
- R4: When `cfg_saf`=1, a packet starts only after its end-of-packet byte has been written, whatever the code.
- R5: After a packet starts, each slot delivers the next byte in write order, registered one cycle after the slot. `tx_last` is set with the end-of-packet byte. If a slot finds the buffer empty before the end-of-packet byte has been sent, `tx_abort` pulses in place of a byte, and the packet's remaining bytes are discarded as they arrive.
- R6: Each underflow sets `irq`. `irq` stays set until an `irq_clr` pulse clears it.
- R7: Each underflow raises the code reported on `st_thr_code` by one, starting from `cfg_thr_code`. An underflow while the code is already 3 sets `st_saf`. From then on, R4 behaviour applies until reset.
- R8: `st_unf_cnt` counts underflows and holds at its all-ones value.
- R9: In hold-until-complete mode, a buffer filled with DEPTH bytes and no end-of-packet byte pulses `err_oversize`. That packet is then discarded up to and including its end-of-packet byte, and is never sent.
- R10: `wr_ready` is low exactly when DEPTH bytes are held. After reset it is high, with no output activity, `irq` low and a zero underflow count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the escalation |
| cfg_thr_code | input | 2 | Software start-level code |
| cfg_fast | input | 1 | Line speed: 1 selects the high-speed table |
| cfg_saf | input | 1 | Hold each packet until it is complete |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Write byte ends its packet |
| wr_ready | output | 1 | Buffer can accept a byte |
| line_slot | input | 1 | One line byte slot this cycle |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Output byte ends the packet |
| tx_abort | output | 1 | Packet aborted by underflow |
| irq | output | 1 | Sticky underflow interrupt |
| irq_clr | input | 1 | Clear pulse for `irq` |
| err_oversize | output | 1 | Pulse: held packet exceeds buffer |
| st_thr_code | output | 2 | Code in effect after escalation |
| st_saf | output | 1 | Hold-until-complete in effect |
| st_unf_cnt | output | UCW | Saturating underflow count |

## Verification
The assertions check rules that hold on every cycle:
- the buffer never holds more than DEPTH bytes;
- no byte leaves while hold-until-complete mode has no complete packet buffered;
- a slot that finds the buffer empty mid-packet always produces an abort and never a byte;
- an abort and a byte never appear together;
- the forced hold mode never lets go;
- `irq` does not drop without a clear.

Only the bench's scenarios can show the rest:
- the exact start level of each of the eight code and speed pairs, found by one-byte-short and exact-fill sweeps;
- the order of the delivered data;
- the four-step ratchet leading to forced hold;
- counter saturation;
- recovery after an oversize discard.

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
  parameter int DEPTH = 2048,
  parameter int UCW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_thr_code,
  input  logic           cfg_fast,
  input  logic           cfg_saf,
  input  logic           wr_valid,
  input  logic [7:0]     wr_data,
  input  logic           wr_last,
  output logic           wr_ready,
  input  logic           line_slot,
  output logic           tx_valid,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  output logic           tx_abort,
  output logic           irq,
  input  logic           irq_clr,
  output logic           err_oversize,
  output logic [1:0]     st_thr_code,
  output logic           st_saf,
  output logic [UCW-1:0] st_unf_cnt
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_FLUSH} state_t;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, eops;
  state_t        st;
  logic [1:0]    esc;
  logic          force_saf;
  logic [2:0]    code_sum;
  logic [1:0]    eff_code;
  logic [10:0]   thr_raw;

  assign code_sum = {1'b0, cfg_thr_code} + {1'b0, esc};
  assign eff_code = code_sum[2] ? 2'd3 : code_sum[1:0];

  always_comb begin
    if (cfg_fast) thr_raw = 11'd128 << eff_code;
    else begin
      case (eff_code)
        2'd0:    thr_raw = 11'd72;
        2'd1:    thr_raw = 11'd96;
        2'd2:    thr_raw = 11'd128;
        default: thr_raw = 11'd160;
      endcase
    end
  end

  logic saf, have_eop, empty, full, head_last, start_ok;
  logic do_wr, pop_send, pop_flush, do_pop, unf, oversz;

  assign saf       = cfg_saf | force_saf;
  assign have_eop  = eops != '0;
  assign empty     = cnt == '0;
  assign full      = cnt == CW'(DEPTH);
  assign head_last = mem[rp][8];
  assign start_ok  = have_eop | (!saf & (int'(cnt) >= int'(thr_raw)));

  assign wr_ready  = !full;
  assign do_wr     = wr_valid & !full;
  assign pop_send  = line_slot & !empty &
                     (((st == S_IDLE) & start_ok) | (st == S_SEND));
  assign pop_flush = (st == S_FLUSH) & !empty;
  assign do_pop    = pop_send | pop_flush;
  assign unf       = (st == S_SEND) & line_slot & empty;
  assign oversz    = (st == S_IDLE) & saf & !have_eop & full;

  assign st_thr_code = eff_code;
  assign st_saf      = saf;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      eops <= '0;
    end else begin
      if (do_wr)  wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      cnt  <= cnt + CW'(do_wr) - CW'(do_pop);
      eops <= eops + CW'(do_wr & wr_last) - CW'(do_pop & head_last);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (oversz) st <= S_FLUSH;
                 else if (pop_send && !head_last) st <= S_SEND;
        S_SEND:  if (unf) st <= S_FLUSH;
                 else if (pop_send && head_last) st <= S_IDLE;
        default: if (pop_flush && head_last) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid     <= 1'b0;
      tx_data      <= '0;
      tx_last      <= 1'b0;
      tx_abort     <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      tx_valid     <= pop_send;
      tx_data      <= mem[rp][7:0];
      tx_last      <= pop_send & head_last;
      tx_abort     <= unf;
      err_oversize <= oversz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      esc        <= '0;
      force_saf  <= 1'b0;
      st_unf_cnt <= '0;
    end else begin
      if (unf) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (unf) begin
        if (eff_code == 2'd3) force_saf <= 1'b1;
        else esc <= esc + 1'b1;
        if (st_unf_cnt != '1) st_unf_cnt <= st_unf_cnt + 1'b1;
      end
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  a_r4_hold_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (saf && st == S_IDLE && !have_eop) |=> !tx_valid);

  a_r5_empty_slot_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && line_slot && empty) |=> (tx_abort && !tx_valid));

  a_r5_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_abort));

  a_r7_saf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    st_saf && !cfg_saf |=> st_saf);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r8_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_unf_cnt == '1) |=> (st_unf_cnt == '1));

endmodule

// File: tb/tx_start_gate_tb_top.sv
module tx_start_gate_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 2048;
  localparam int UCW   = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_thr_code = 0;
  logic cfg_fast = 0, cfg_saf = 0;
  logic wr_valid = 0, wr_last = 0, line_slot = 0, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, tx_valid, tx_last, tx_abort, irq, err_oversize, st_saf;
  logic [7:0] tx_data;
  logic [1:0] st_thr_code;
  logic [UCW-1:0] st_unf_cnt;

  int checks = 0, fails = 0;
  int tx_cnt = 0, last_cnt = 0, abort_cnt = 0, err_cnt = 0, rx_idx = 0, seed = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_start_gate #(.DEPTH(DEPTH), .UCW(UCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_thr_code(cfg_thr_code), .cfg_fast(cfg_fast),
    .cfg_saf(cfg_saf), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .line_slot(line_slot), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort), .irq(irq),
    .irq_clr(irq_clr), .err_oversize(err_oversize), .st_thr_code(st_thr_code),
    .st_saf(st_saf), .st_unf_cnt(st_unf_cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) rx_idx = 0;
    else begin
      if (tx_valid) begin
        chk(tx_data == 8'(rx_idx + seed), "R5 data order", int'(tx_data), (rx_idx + seed) % 256);
        tx_cnt++;
        rx_idx++;
        if (tx_last) begin last_cnt++; rx_idx = 0; end
      end
      if (tx_abort) begin abort_cnt++; rx_idx = 0; end
      if (err_oversize) err_cnt++;
    end
  end

  function automatic int level(input int fast, input int code);
    if (fast != 0) return 128 << code;
    return (code < 2) ? 72 + 24 * code : 128 + 32 * (code - 2);
  endfunction

  task automatic push(input int idx, input bit lst);
    @(negedge clk);
    wr_valid = 1; wr_data = 8'(idx + seed); wr_last = lst;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 0; wr_last = 0;
  endtask

  task automatic push_range(input int from, input int upto, input bit lst);
    for (int i = from; i < upto; i++) push(i, lst && (i == upto - 1));
  endtask

  task automatic slots(input int n);
    @(negedge clk); line_slot = 1;
    repeat (n) @(negedge clk);
    line_slot = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; line_slot = 0; wr_valid = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mark, lmark, amark, t;
    cfg_thr_code = 2; cfg_fast = 1;
    do_reset();
    chk(wr_ready == 1, "R10 reset wr_ready", wr_ready, 1);
    chk(tx_valid == 0 && tx_abort == 0, "R10 reset idle out", tx_valid, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);
    chk(st_unf_cnt == 0, "R10 reset count", st_unf_cnt, 0);
    chk(st_thr_code == 2 && st_saf == 0, "R10 reset status", st_thr_code, 2);

    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 4; c++) begin
        cfg_fast = f[0]; cfg_thr_code = 2'(c); cfg_saf = 0;
        do_reset();
        seed = f * 4 + c;
        t = level(f, c);
        mark = tx_cnt; lmark = last_cnt; amark = abort_cnt;
        push_range(0, t - 1, 0);
        slots(4);
        chk(tx_cnt == mark, f ? "R2 below level" : "R1 below level", tx_cnt - mark, 0);
        push_range(t - 1, t, 0);
        slots(1);
        chk(tx_cnt == mark + 1, f ? "R2 at level" : "R1 at level", tx_cnt - mark, 1);
        push_range(t, t + 3, 1);
        slots(t + 8);
        chk(tx_cnt == mark + t + 3 && last_cnt == lmark + 1 && abort_cnt == amark,
            "R5 full packet", tx_cnt - mark, t + 3);
      end
    end

    cfg_fast = 0; cfg_thr_code = 3; cfg_saf = 0;
    do_reset();
    seed = 40; mark = tx_cnt; lmark = last_cnt;
    push_range(0, 10, 1);
    slots(14);
    chk(tx_cnt == mark + 10 && last_cnt == lmark + 1, "R3 short packet", tx_cnt - mark, 10);

    cfg_fast = 0; cfg_thr_code = 0; cfg_saf = 1;
    do_reset();
    seed = 50; mark = tx_cnt;
    @(negedge clk); line_slot = 1;
    push_range(0, 100, 0);
    repeat (3) @(negedge clk);
    chk(tx_cnt == mark, "R4 hold until last", tx_cnt - mark, 0);
    push_range(100, 101, 1);
    repeat (110) @(negedge clk);
    chk(tx_cnt == mark + 101, "R4 complete packet sent", tx_cnt - mark, 101);
    line_slot = 0;

    cfg_fast = 1; cfg_thr_code = 0; cfg_saf = 0;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      seed = 60 + k;
      t = 128 << k;
      chk(st_thr_code == 2'(k), "R7 code before round", st_thr_code, k);
      mark = tx_cnt; amark = abort_cnt;
      push_range(0, t, 0);
      slots(t + 4);
      chk(tx_cnt == mark + t, "R5 bytes before abort", tx_cnt - mark, t);
      chk(abort_cnt == amark + 1, "R5 abort strobe", abort_cnt - amark, 1);
      chk(int'(st_unf_cnt) == ((k + 1 > 3) ? 3 : k + 1), "R8 saturating count",
          st_unf_cnt, (k + 1 > 3) ? 3 : k + 1);
      chk(irq == 1, "R6 irq set", irq, 1);
      push_range(t, t + 1, 1);
      repeat (3) @(negedge clk);
      if (k < 3) chk(st_thr_code == 2'(k + 1) && st_saf == 0, "R7 step up", st_thr_code, k + 1);
      else chk(st_thr_code == 3 && st_saf == 1, "R7 forced hold", st_saf, 1);
    end
    repeat (5) @(negedge clk);
    chk(irq == 1, "R6 irq sticky", irq, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R6 irq cleared", irq, 0);

    seed = 70; mark = tx_cnt; amark = err_cnt;
    @(negedge clk); line_slot = 1;
    push_range(0, 1100, 0);
    repeat (3) @(negedge clk);
    chk(tx_cnt == mark, "R7 forced hold blocks start", tx_cnt - mark, 0);
    push_range(1100, DEPTH, 0);
    repeat (3) @(negedge clk);
    chk(err_cnt == amark + 1, "R9 oversize flagged", err_cnt - amark, 1);
    push_range(DEPTH, DEPTH + 6, 1);
    repeat (DEPTH + 20) @(negedge clk);
    chk(tx_cnt == mark, "R9 oversize discarded", tx_cnt - mark, 0);
    seed = 80; lmark = last_cnt;
    push_range(0, 20, 1);
    repeat (30) @(negedge clk);
    chk(tx_cnt == mark + 20 && last_cnt == lmark + 1, "R9 recovery", tx_cnt - mark, 20);
    line_slot = 0;

    cfg_fast = 1; cfg_thr_code = 0; cfg_saf = 0;
    do_reset();
    seed = 90; mark = tx_cnt; amark = abort_cnt;
    push_range(0, DEPTH, 0);
    @(negedge clk);
    chk(wr_ready == 0, "R10 full backpressure", wr_ready, 0);
    line_slot = 1;
    push_range(DEPTH, DEPTH + 1, 1);
    repeat (DEPTH + 10) @(negedge clk);
    chk(tx_cnt == mark + DEPTH + 1 && abort_cnt == amark, "R10 drain after full",
        tx_cnt - mark, DEPTH + 1);
    chk(wr_ready == 1, "R10 ready after drain", wr_ready, 1);
    line_slot = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule